// File: doc/BRIEF.md
# Serial Command Front End for an Eight-Channel 8-bit DAC

This block is the digital side of an eight-channel, 8-bit digital-to-analog converter. A host sends 16-bit command words over a synchronous serial link made of a serial clock, an active-low chip select, and a data line. A fourth line, an active-low load strobe, is optional. All four pins are sampled by one fast system clock. Each command word names a channel and an operation. The operation takes effect when chip select is released, and only if the word held exactly sixteen serial clocks.

Every channel has two 8-bit stages. The first is a staging (input) register that commands can write. The second is an output (DAC) register, whose value leaves the block on `dac_val`. A serial output returns each incoming bit sixteen serial clocks after it arrived, so that several devices can share one chain. The edge on which this output changes can be chosen by command. When idle, the serial output holds its level.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, every staging and output register reads zero, `sdo` is 0, the stored frame bits are zero, and the echo launches on the falling serial edge.
- R2: A data bit is taken only on a synchronized rising edge of `sck` while `cs_n` is low. Edges of `sck` seen while `cs_n` is high change nothing.
- R3: Words are sent MSB first. Bits 15..14 are ignored, bits 13..11 give the channel, bits 10..8 give the operation code, and bits 7..0 give the data.
- R4: A command runs on the synchronized rising edge of `cs_n`, and only if exactly 16 `sck` rises were counted since `cs_n` fell. `dac_val` changes on the third system clock edge after the pin change. Any other count discards the word.
- R5: Code 1 writes the data to the staging register of the addressed channel only.
- R6: Code 2 writes the data to both the staging register and the output register of the addressed channel.
- R7: Code 3 writes the data to all staging registers. Code 4 writes it to all staging and all output registers.
- R8: Code 5 copies every staging register into its output register. Codes 0 and 7 change no register.
- R9: Code 6 sets the echo edge from bit 13 of the word: 1 selects the rising edge, 0 selects the falling edge. No other code alters the echo edge.
- R10: At each counted rise, `sdo` takes the bit that entered 16 rises earlier (zero if there is none) when the rising mode is set. In falling mode, that bit appears at the next `sck` fall while `cs_n` is still low. `sdo` never changes while `cs_n` is high.
- R11: A falling edge on `load_n` copies all staging registers to the output registers, whatever `sck` and `cs_n` are doing.
- R12: When a load-strobe copy and a command that writes an output register fall in the same system cycle, the command's value is the one kept for the channels it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| load_n | input | 1 | Active-low load strobe; its falling edge copies staging to output registers |
| sdo | output | 1 | Serial data out, delayed by 16 serial clocks |
| dac_val | output | 64 | Output registers; channel i sits at bits 8i+7..8i |

## Verification
The collision that matters is a load-strobe copy landing in the same system cycle as a command that writes output registers. The bench provokes it by driving `load_n` low on the same clock as the release of `cs_n`. Both pins pass through identical synchronizer depths, so the two events reach the register bank together. The collision is run with a broadcast write and again with a single-channel write after the staging values have been made to differ. The result is judged against a behavioural model that applies the copy first and the command second, and against hand-computed channel values.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WR_IN   = 3'd1,
    OP_WR_BOTH = 3'd2,
    OP_BC_IN   = 3'd3,
    OP_BC_BOTH = 3'd4,
    OP_XFER    = 3'd5,
    OP_EDGE    = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;
  localparam int OP_W = 3;
  localparam int PAD_W = 2;
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = async_in;
      end else begin : g_next
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VEC;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
`timescale 1ns/1ps
module sdac_shifter #(
  parameter int FRAME_W = 16,
  localparam int CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               cs_act,
  input  logic               cs_end,
  input  logic               sdi_s,
  input  logic               edge_rise_mode,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_ok,
  output logic               sdo
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shr_q, shr_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               pend_q, pend_n;
  logic               sdo_q, sdo_n;

  always_comb begin
    shr_n  = shr_q;
    cnt_n  = cnt_q;
    pend_n = pend_q;
    sdo_n  = sdo_q;
    if (!cs_act) begin
      cnt_n = '0;
    end else if (sck_rise) begin
      shr_n  = {shr_q[FRAME_W-2:0], sdi_s};
      pend_n = shr_q[FRAME_W-1];
      if (cnt_q != CNT_SAT) cnt_n = cnt_q + 1'b1;
      if (edge_rise_mode) sdo_n = shr_q[FRAME_W-1];
    end else if (sck_fall && !edge_rise_mode) begin
      sdo_n = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      shr_q  <= shr_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      sdo_q  <= sdo_n;
    end
  end

  assign frame    = shr_q;
  assign frame_ok = cs_end && (cnt_q == CNT_FULL);
  assign sdo      = sdo_q;

  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable(sdo_q));
endmodule

// File: rtl/sdac_regbank.sv
`timescale 1ns/1ps
module sdac_regbank
  import sdac_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW = 8,
  localparam int AW = $clog2(NUM_CH),
  localparam int CMD_W = AW + OP_W + DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_v,
  input  logic [CMD_W-1:0]     cmd,
  input  logic                 ldac_fire,
  output logic [NUM_CH*DW-1:0] dac_flat,
  output logic                 edge_mode
);
  logic [NUM_CH-1:0][DW-1:0] in_q, in_n;
  logic [NUM_CH-1:0][DW-1:0] dac_q, dac_n;
  logic                      mode_q, mode_n;

  logic [AW-1:0] cmd_addr;
  op_e           cmd_op;
  logic [DW-1:0] cmd_data;

  assign cmd_data = cmd[DW-1:0];
  assign cmd_op   = op_e'(cmd[DW+OP_W-1:DW]);
  assign cmd_addr = cmd[CMD_W-1:DW+OP_W];

  always_comb begin
    in_n   = in_q;
    dac_n  = ldac_fire ? in_q : dac_q;
    mode_n = mode_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (exec_v) begin
        case (cmd_op)
          OP_WR_IN: begin
            if (cmd_addr == AW'(i)) in_n[i] = cmd_data;
          end
          OP_WR_BOTH: begin
            if (cmd_addr == AW'(i)) begin
              in_n[i]  = cmd_data;
              dac_n[i] = cmd_data;
            end
          end
          OP_BC_IN: in_n[i] = cmd_data;
          OP_BC_BOTH: begin
            in_n[i]  = cmd_data;
            dac_n[i] = cmd_data;
          end
          OP_XFER: dac_n[i] = in_q[i];
          default: ;
        endcase
      end
    end
    if (exec_v && (cmd_op == OP_EDGE)) mode_n = cmd_addr[AW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      dac_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      in_q   <= in_n;
      dac_q  <= dac_n;
      mode_q <= mode_n;
    end
  end

  assign dac_flat  = dac_q;
  assign edge_mode = mode_q;

  // R11
  ldac_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fire && !exec_v) |=> (dac_q == $past(in_q)));

  // R12
  ldac_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fire && exec_v && (cmd_op == OP_BC_BOTH)) |=> (dac_q == {NUM_CH{$past(cmd_data)}}));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_v && (cmd_op == OP_EDGE)) |=> $stable(mode_q));
endmodule

// File: rtl/sdac_frontend.sv
`timescale 1ns/1ps
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck,
  input  logic                 cs_n,
  input  logic                 sdi,
  input  logic                 load_n,
  output logic                 sdo,
  output logic [NUM_CH*DW-1:0] dac_val
);
  localparam int AW = $clog2(NUM_CH);
  localparam int CMD_W = AW + OP_W + DW;
  localparam int FRAME_W = PAD_W + CMD_W;
  localparam int P_SCK = 0;
  localparam int P_CS  = 1;
  localparam int P_SDI = 2;
  localparam int P_LD  = 3;

  logic [3:0] pins_raw, pins_s;
  logic [2:0] prev_q, prev_n;

  assign pins_raw = {load_n, sdi, cs_n, sck};

  sdac_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VEC(4'b1010)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pins_raw),
    .sync_out(pins_s)
  );

  always_comb prev_n = {pins_s[P_LD], pins_s[P_CS], pins_s[P_SCK]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 3'b110;
    else        prev_q <= prev_n;
  end

  logic sck_rise, sck_fall, cs_act, cs_end, ldac_fire;
  assign sck_rise  =  pins_s[P_SCK] & ~prev_q[0];
  assign sck_fall  = ~pins_s[P_SCK] &  prev_q[0];
  assign cs_act    = ~pins_s[P_CS];
  assign cs_end    =  pins_s[P_CS] & ~prev_q[1];
  assign ldac_fire = ~pins_s[P_LD] &  prev_q[2];

  logic [FRAME_W-1:0] frame;
  logic               frame_ok;
  logic               edge_mode;

  sdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_rise      (sck_rise),
    .sck_fall      (sck_fall),
    .cs_act        (cs_act),
    .cs_end        (cs_end),
    .sdi_s         (pins_s[P_SDI]),
    .edge_rise_mode(edge_mode),
    .frame         (frame),
    .frame_ok      (frame_ok),
    .sdo           (sdo)
  );

  sdac_regbank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_v   (frame_ok),
    .cmd      (frame[CMD_W-1:0]),
    .ldac_fire(ldac_fire),
    .dac_flat (dac_val),
    .edge_mode(edge_mode)
  );

  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok || ldac_fire) |=> $stable(dac_val));
endmodule

// File: tb/tb_sdac_frontend.sv
`timescale 1ns/1ps
module tb_sdac_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, load_n = 1'b1;
  logic sdo;
  logic [63:0] dac_val;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  sdac_frontend dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .load_n(load_n), .sdo(sdo), .dac_val(dac_val)
  );

  // behavioural reference model
  bit [2:0] ms, mc, md, ml;
  bit       hist[$];
  int       m_cnt;
  bit       m_mode, m_sdo, m_pend, echo;
  bit [7:0] m_in[8], m_dac[8], old_in[8];
  bit       srise, sfall, act, cend, lfire;
  bit [15:0] w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 3'b000; mc = 3'b111; md = 3'b000; ml = 3'b111;
      hist.delete();
      m_cnt = 0; m_mode = 0; m_sdo = 0; m_pend = 0;
      for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_dac[i] = 0; end
    end else begin
      srise = ms[1] & ~ms[2];
      sfall = ~ms[1] & ms[2];
      act   = ~mc[1];
      cend  = mc[1] & ~mc[2];
      lfire = ~ml[1] & ml[2];
      old_in = m_in;
      if (lfire) m_dac = old_in;
      if (!act) begin
        if (cend && m_cnt == 16) begin
          w = 0;
          for (int k = 0; k < 16; k++) begin
            int idx;
            idx = hist.size() - 16 + k;
            w = {w[14:0], (idx >= 0) ? hist[idx] : 1'b0};
          end
          for (int i = 0; i < 8; i++) begin
            case (w[10:8])
              3'd1: if (w[13:11] == i) m_in[i] = w[7:0];
              3'd2: if (w[13:11] == i) begin m_in[i] = w[7:0]; m_dac[i] = w[7:0]; end
              3'd3: m_in[i] = w[7:0];
              3'd4: begin m_in[i] = w[7:0]; m_dac[i] = w[7:0]; end
              3'd5: m_dac[i] = old_in[i];
              default: ;
            endcase
          end
          if (w[10:8] == 3'd6) m_mode = w[13];
        end
        m_cnt = 0;
      end else if (srise) begin
        echo = (hist.size() >= 16) ? hist[hist.size()-16] : 1'b0;
        hist.push_back(md[1]);
        while (hist.size() > 32) void'(hist.pop_front());
        if (m_cnt < 17) m_cnt++;
        m_pend = echo;
        if (m_mode) m_sdo = echo;
      end else if (sfall && !m_mode) begin
        m_sdo = m_pend;
      end
      ms = {ms[1:0], sck};
      mc = {mc[1:0], cs_n};
      md = {md[1:0], sdi};
      ml = {ml[1:0], load_n};
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [63:0] exp_flat;
      for (int i = 0; i < 8; i++) exp_flat[i*8 +: 8] = m_dac[i];
      checks++;
      if (sdo !== m_sdo) begin
        fails++;
        $display("FAIL R10 sdo actual=%b expected=%b t=%0t", sdo, m_sdo, $time);
      end
      checks++;
      if (dac_val !== exp_flat) begin
        fails++;
        $display("FAIL %s dac_val actual=%h expected=%h t=%0t", cur_req, dac_val, exp_flat, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic [15:0] fw(input bit [1:0] pad, input int ch, input int op, input bit [7:0] d);
    bit [2:0] c3, o3;
    c3 = ch[2:0];
    o3 = op[2:0];
    return {pad, c3, o3, d};
  endfunction

  task automatic send(input bit [15:0] word, input int nclk, input bit ld_at_end);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b0;
      tick(4);
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    if (ld_at_end) load_n = 1'b0;
    tick(6);
    load_n = 1'b1;
    tick(4);
  endtask

  task automatic check_ch(input int ch, input bit [7:0] exp, input string req);
    checks++;
    if (dac_val[ch*8 +: 8] !== exp) begin
      fails++;
      $display("FAIL %s channel %0d actual=%h expected=%h", req, ch, dac_val[ch*8 +: 8], exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    cur_req = "R1";
    checks++;
    if (dac_val !== 64'h0 || sdo !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", dac_val, sdo);
    end
    // R5 staging write only
    cur_req = "R5";
    send(fw(2'b00, 3, 1, 8'hA5), 16, 0);
    check_ch(3, 8'h00, "R5");
    // R8 transfer all
    cur_req = "R8";
    send(fw(2'b00, 0, 5, 8'h00), 16, 0);
    check_ch(3, 8'hA5, "R8");
    // R6 + R3 single write, pad bits set
    cur_req = "R6";
    send(fw(2'b11, 5, 2, 8'h3C), 16, 0);
    check_ch(5, 8'h3C, "R6");
    check_ch(3, 8'hA5, "R3");
    // R4 short and long frames discarded
    cur_req = "R4";
    send(fw(2'b00, 1, 2, 8'h77), 15, 0);
    check_ch(1, 8'h00, "R4");
    send(fw(2'b00, 1, 2, 8'h77), 17, 0);
    check_ch(1, 8'h00, "R4");
    // R2 clocks with chip select high ignored
    cur_req = "R2";
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(4);
    send(fw(2'b00, 1, 2, 8'h5A), 16, 0);
    check_ch(1, 8'h5A, "R2");
    // R7 broadcasts
    cur_req = "R7";
    send(fw(2'b00, 0, 3, 8'h11), 16, 0);
    check_ch(6, 8'h00, "R7");
    send(fw(2'b00, 2, 4, 8'h22), 16, 0);
    check_ch(0, 8'h22, "R7");
    check_ch(7, 8'h22, "R7");
    // R8 no-op and reserved codes
    cur_req = "R8";
    send(fw(2'b00, 4, 0, 8'hEE), 16, 0);
    send(fw(2'b00, 4, 7, 8'hEE), 16, 0);
    send(fw(2'b00, 0, 5, 8'h00), 16, 0);
    check_ch(4, 8'h22, "R8");
    // R11 load strobe
    cur_req = "R11";
    send(fw(2'b00, 6, 1, 8'h99), 16, 0);
    check_ch(6, 8'h22, "R11");
    load_n = 1'b0; tick(6); load_n = 1'b1; tick(4);
    check_ch(6, 8'h99, "R11");
    // R11 strobe in mid-frame
    send(fw(2'b00, 2, 1, 8'h44), 16, 0);
    cs_n = 1'b0; tick(4);
    sdi = 1'b1; tick(4); sck = 1'b1; load_n = 1'b0; tick(4); sck = 1'b0; load_n = 1'b1;
    tick(4); cs_n = 1'b1; tick(8);
    check_ch(2, 8'h44, "R11");
    // R9 + R10 rising mode echo
    cur_req = "R9";
    send(fw(2'b00, 4, 6, 8'h00), 16, 0);
    cur_req = "R10";
    send(fw(2'b01, 0, 0, 8'hC3), 16, 0);
    send(fw(2'b10, 0, 7, 8'h96), 16, 0);
    cur_req = "R9";
    send(fw(2'b00, 3, 6, 8'h00), 16, 0);
    cur_req = "R10";
    send(fw(2'b11, 5, 0, 8'h69), 16, 0);
    send(fw(2'b00, 0, 0, 8'h00), 16, 0);
    // R12 collisions: broadcast then single channel
    cur_req = "R12";
    send(fw(2'b00, 1, 1, 8'h55), 16, 0);
    send(fw(2'b00, 2, 4, 8'h66), 16, 1);
    check_ch(1, 8'h66, "R12");
    send(fw(2'b00, 0, 1, 8'h10), 16, 0);
    send(fw(2'b00, 7, 2, 8'h80), 16, 1);
    check_ch(0, 8'h10, "R12");
    check_ch(7, 8'h80, "R12");
    tick(10);
    finish_run();
  end
endmodule